// File: doc/BRIEF.md
# Mains-Loss Missing-Pulse Detector

This block watches a squared-up pulse train taken from the AC mains and tells the rest of the chip whether mains power is still present. Every rising edge of the pulse train restarts a timeout counter that runs on the system clock. As long as edges keep arriving, the block reports power as good. When the edges stop for longer than a window of two mains periods, the block drops the good level and raises a failure level. That failure level is meant to drive a non-maskable interrupt request, so that software can save its state while the supply capacitors still hold up the rails.

The pulse input is asynchronous to the system clock. It passes through a synchroniser, and only its rising edge counts as a pulse. One mains period, in clock cycles, is a parameter, and the timeout window is twice that value. After reset the block waits in an armed state with both outputs low until the first pulse shows up. From then on exactly one of the two outputs is high.

Top module: `mains_loss_det`

## Requirements
- R1: After reset `powerGood` and `failReq` are both 0, and they stay 0 until the first rising edge on `pulseAsync`.
- R2: `pulseAsync` is sampled through two flops. A rising edge that is set up before clock edge a shows as `powerGood`=1 (with `failReq`=0) from clock edge a+2 onward.
- R3: Only a 0-to-1 transition of `pulseAsync` restarts the window. An input held high counts as one pulse and leads to failure once the window runs out.
- R4: The window is W = 2*`PERIOD_CYCLES` clock cycles. If successive rising edges are at most W cycles apart, `powerGood` stays 1 and `failReq` stays 0.
- R5: If no rising edge follows within W cycles of the last one, `failReq` becomes 1 and `powerGood` becomes 0 at clock edge a+W+2, where a is the first clock edge after that last rise. A gap of W+1 cycles is enough to cause a failure.
- R6: `powerGood` and `failReq` are never 1 together. After the first pulse, exactly one of them is 1.
- R7: Once set, `failReq` stays 1 until a new rising edge arrives. That edge restores `powerGood` with the same two-cycle latency as in R2.
- R8: Asserting `rstN` at any time returns the block to the armed state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseAsync | input | 1 | Squared-up mains pulse train, asynchronous to `clk` |
| powerGood | output | 1 | High while mains pulses keep arriving within the window |
| failReq | output | 1 | High after the pulses have stopped; drives the non-maskable interrupt request |

## Verification
Every result follows a rise of the pulse input by a fixed number of clock edges. A rise driven before clock edge a takes effect at edge a+2, and a missing pulse takes effect at edge a+W+2. The bench drives its inputs and samples the outputs on falling edges. It keeps a list of the falling-edge times at which it made a rise. From that list it works out the expected state at each sample: a rise becomes visible three falling edges later, and a failure becomes visible W+3 falling edges after the last visible rise. With this, the bench checks every cycle of a sweep of gaps between pulses, from 2 cycles up to well past W. The sweep includes the boundary pair W and W+1.

// File: rtl/mld_pkg.sv
package mld_pkg;

  // Strobes from the control FSM to the timeout datapath
  typedef struct packed {
    logic clrCnt;   // restart the window at zero
    logic runCnt;   // advance the window counter
  } cntCtrl_t;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,  // waiting for the first pulse after reset
    ST_GOOD  = 2'd1,  // pulses arriving within the window
    ST_FAIL  = 2'd2   // window expired, interrupt requested
  } monState_t;

endpackage

// File: rtl/mld_datapath.sv
module mld_datapath
  import mld_pkg::*;
#(
  parameter int WINDOW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pulseAsync,
  input  cntCtrl_t ctrl,
  output logic     riseSeen,
  output logic     expired
);

  localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   prevLevel;
  logic [CNT_W-1:0]       cnt;

  // Synchroniser chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[0] <= 1'b0;
          else       syncReg[0] <= pulseAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[gi] <= 1'b0;
          else       syncReg[gi] <= syncReg[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncReg[SYNC_STAGES-1];
  end

  assign riseSeen = syncReg[SYNC_STAGES-1] & ~prevLevel;

  // Window counter: cleared on a pulse, saturates at WINDOW-1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            cnt <= '0;
    else if (ctrl.clrCnt)                 cnt <= '0;
    else if (ctrl.runCnt && cnt != LAST)  cnt <= cnt + CNT_W'(1);
  end

  assign expired = (cnt == LAST);

  // R4: a pulse restarts the window from zero
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrCnt |=> (cnt == '0));

  // R4: the window advances by one per cycle while running
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.runCnt && !ctrl.clrCnt && !expired) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R3: a detected rise lasts a single cycle
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    riseSeen |=> !riseSeen);

endmodule

// File: rtl/mld_control.sv
module mld_control
  import mld_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     riseSeen,
  input  logic     expired,
  output cntCtrl_t ctrl,
  output logic     powerGood,
  output logic     failReq
);

  monState_t state, nextState;

  always_comb begin
    nextState   = state;
    ctrl.clrCnt = 1'b0;
    ctrl.runCnt = 1'b0;
    case (state)
      ST_ARMED: begin
        if (riseSeen) begin
          nextState   = ST_GOOD;
          ctrl.clrCnt = 1'b1;
        end
      end
      ST_GOOD: begin
        ctrl.runCnt = 1'b1;
        if (riseSeen)     ctrl.clrCnt = 1'b1;
        else if (expired) nextState   = ST_FAIL;
      end
      ST_FAIL: begin
        if (riseSeen) begin
          nextState   = ST_GOOD;
          ctrl.clrCnt = 1'b1;
        end
      end
      default: nextState = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= nextState;
  end

  assign powerGood = (state == ST_GOOD);
  assign failReq   = (state == ST_FAIL);

  // R5: failure is raised only from an expired window with no pulse
  p_fail_from_timeout_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failReq) |-> ($past(expired) && !$past(riseSeen)));

  // R7: any detected rise leads to the good state
  p_rise_restores_r7: assert property (@(posedge clk) disable iff (!rstN)
    riseSeen |=> powerGood);

  // R7: failure holds until a rise arrives
  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (failReq && !riseSeen) |=> failReq);

  // R4: good holds while the window is still open
  p_good_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && !expired) |=> powerGood);

endmodule

// File: rtl/mains_loss_det.sv
module mains_loss_det
  import mld_pkg::*;
#(
  parameter int PERIOD_CYCLES = 1_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pulseAsync,
  output logic powerGood,
  output logic failReq
);

  localparam int WINDOW = 2 * PERIOD_CYCLES;

  cntCtrl_t ctrl;
  logic     riseSeen;
  logic     expired;

  mld_datapath #(
    .WINDOW      (WINDOW),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .pulseAsync (pulseAsync),
    .ctrl       (ctrl),
    .riseSeen   (riseSeen),
    .expired    (expired)
  );

  mld_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .riseSeen  (riseSeen),
    .expired   (expired),
    .ctrl      (ctrl),
    .powerGood (powerGood),
    .failReq   (failReq)
  );

  // R6: the two outputs are never high together
  p_outputs_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(powerGood && failReq));

endmodule

// File: tb/mains_loss_det_bench.sv
module mains_loss_det_bench;

  localparam int PERIOD = 4;
  localparam int W      = 2 * PERIOD;

  logic clk = 1'b0;
  logic rstN;
  logic pulseAsync;
  logic powerGood;
  logic failReq;

  int t      = 0;
  int checks = 0;
  int errors = 0;
  int rises[$];

  always #10 clk = ~clk;   // 50 MHz

  mains_loss_det #(.PERIOD_CYCLES(PERIOD)) u_mains_loss_det (
    .clk        (clk),
    .rstN       (rstN),
    .pulseAsync (pulseAsync),
    .powerGood  (powerGood),
    .failReq    (failReq)
  );

  task automatic advance();
    @(negedge clk);
    t++;
  endtask

  task automatic drive(input logic v);
    if (v && !pulseAsync) rises.push_back(t);
    pulseAsync = v;
  endtask

  // Expected state from rise times: 0 armed, 1 good, 2 fail
  function automatic int expState();
    int r;
    bit found;
    found = 1'b0;
    r     = 0;
    for (int i = rises.size() - 1; i >= 0; i--) begin
      if (!found && rises[i] + 3 <= t) begin
        r     = rises[i];
        found = 1'b1;
      end
    end
    if (!found)         return 0;
    if (t >= r + W + 3) return 2;
    return 1;
  endfunction

  task automatic checkNow(input string phase);
    int    e;
    logic  expGood, expFail;
    string req;
    e       = expState();
    expGood = (e == 1);
    expFail = (e == 2);
    req     = (e == 0) ? "R1" : ((e == 1) ? "R4" : "R5");
    checks++;
    if (powerGood !== expGood || failReq !== expFail) begin
      errors++;
      $display("FAIL %s (%s) t=%0d: actual good=%b fail=%b expected good=%b fail=%b",
               req, phase, t, powerGood, failReq, expGood, expFail);
    end
    checks++;
    if ((powerGood && failReq) || (e != 0 && (powerGood ^ failReq) !== 1'b1)) begin
      errors++;
      $display("FAIL R6 (%s) t=%0d: actual good=%b fail=%b expected exactly one high",
               phase, t, powerGood, failReq);
    end
  endtask

  task automatic idle(input int n, input string phase);
    repeat (n) begin
      advance();
      checkNow(phase);
    end
  endtask

  // One-cycle pulse followed by (gap-1) low cycles
  task automatic pulseGap(input int gap, input string phase);
    drive(1'b1);
    advance();
    checkNow(phase);
    drive(1'b0);
    idle(gap - 1, phase);
  endtask

  task automatic doReset(input string phase);
    rstN = 1'b0;
    rises.delete();
    #1;
    checks++;
    if (powerGood !== 1'b0 || failReq !== 1'b0) begin
      errors++;
      $display("FAIL R8 (%s): actual good=%b fail=%b expected good=0 fail=0",
               phase, powerGood, failReq);
    end
    idle(3, phase);
    rstN = 1'b1;
  endtask

  initial begin
    rstN       = 1'b0;
    pulseAsync = 1'b0;
    advance();
    doReset("R1 power-on reset");
    idle(6, "R1 armed, no pulse");

    // R2: first pulse, good appears three falling edges after the rise
    pulseGap(6, "R2 first pulse latency");

    // R4/R5/R7: sweep of gaps around the window W
    for (int g = 2; g <= W + 4; g++) begin
      pulseGap(g, "R4 R5 gap sweep");
    end
    pulseGap(W, "R7 recovery after sweep");

    // R3: input held high is a single pulse
    drive(1'b1);
    idle(W + 8, "R3 held high");
    drive(1'b0);
    idle(4, "R3 falling edge ignored");

    // R7: failure held while idle, cleared by a new pulse
    idle(6, "R7 fail held");
    pulseGap(5, "R7 recovery pulse");

    // R5: long silence from good
    idle(W + 4, "R5 silence");

    // R8: reset while good returns to armed
    pulseGap(4, "R8 pre-reset pulse");
    doReset("R8 reset while good");
    idle(W + 6, "R8 armed after reset");
    pulseGap(W, "R8 wake after reset");
    pulseGap(W + 1, "R5 boundary W+1");
    idle(W + 4, "R5 final silence");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1-R8 watchdog: actual still running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule